// File: doc/BRIEF.md
# Genlock Vertical Sync Controller

This block decides, on every dot clock, whether the display timing generator must jump back to the start of a frame or field. In its simplest mode it just forwards the end-of-frame pulse of the local free-running vertical timer. With genlock turned on, the frame start is taken from an external video-input VSYNC instead. That VSYNC is brought into the dot-clock domain, its rising edge is detected and then delayed by a programmable number of dot clocks before the restart is issued.

When the local timer finishes a frame before the external VSYNC has arrived, the block holds and raises a read-only wait status. If the video input reports loss of sync and the timeout fallback is allowed, the block stops waiting. It restarts from the local timer at once, with no skew delay. If the fallback is not allowed, the block keeps waiting for the external VSYNC however long that takes.

The configuration is a single control word held stable by the register block. The restart pulse and the status bit are plain level signals, not streams, so there is no handshake or back-pressure at the edge of the block.

Top module: `gvs_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the restart output, the wait status, the skew countdown and the VSYNC synchronizer. Both outputs read 0 on the cycle after reset.
- R2: With genlock on (control bit SKEW_W, that is 18) and a skew of 0, a rising external VSYNC produces one single-cycle restart pulse. Counting the first rising clock edge that samples VSYNC high as edge 1, the pulse is visible right after edge 3.
- R3: With genlock on and a skew of N, the single restart pulse is visible right after edge 3+N, counted in the same way as in R2.
- R4: A second rising VSYNC edge detected while a skew countdown is running is dropped. Only one restart pulse results and nothing is left pending.
- R5: With genlock off, the restart output equals the end-of-frame input delayed by one clock. The wait status stays 0 and the external VSYNC has no effect.
- R6: With genlock on and no fallback, an end-of-frame pulse sets the wait status on the next cycle. It stays set until the restart caused by the external VSYNC is issued, and it clears in that same cycle.
- R7: With the timeout fallback disabled (control bit SKEW_W+1, that is 19, at 0), a reported sync loss neither releases the wait nor produces a restart.
- R8: With genlock on, the fallback enabled and sync loss reported, an end-of-frame pulse gives a restart on the next cycle. No wait is set and the external VSYNC edges produce no restart.
- R9: If the fallback conditions become true while the wait status is set, a restart is issued on the next cycle and the wait status clears.
- R10: If the fallback conditions become true during a skew countdown, a restart is issued on the next cycle. The remaining skew is abandoned and no further pulse follows.
- R11: The control word carries the skew count in bits 17:0, genlock enable in bit 18 and timeout enable in bit 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_vsync | input | 1 | External VSYNC from the video input, asynchronous |
| vin_sync_lost | input | 1 | Video input reports loss of sync |
| tmr_frame_end | input | 1 | Single-cycle end-of-frame pulse from the local vertical timer |
| ctrl_word | input | 20 | Skew [17:0], genlock enable [18], timeout enable [19] |
| frame_restart | output | 1 | Single-cycle pulse: restart timing at frame or field start |
| wait_status | output | 1 | Read-only: frame done, holding for the external VSYNC |

## Verification
The hardest situation to reach is a fallback that interrupts an activity already in progress. This means sync loss arriving in the middle of a skew countdown, or during a wait hold, where the restart must come at once and no late pulse may follow. The bench programs a long skew and raises VSYNC. It then raises sync loss a known number of clocks later, checks the pulse on the very next cycle and watches a long window for any stray second pulse. A second VSYNC edge placed inside a countdown is timed through the two synchronizer flops, so that its detection falls well inside the busy window.

// File: rtl/gvs_pkg.sv
package gvs_pkg;

  typedef enum logic [1:0] {
    GL_OFF      = 2'd0,
    GL_LOCKED   = 2'd1,
    GL_FALLBACK = 2'd2
  } gl_mode_e;

  function automatic gl_mode_e pick_mode(input logic gl_on,
                                         input logic to_on,
                                         input logic lost);
    if (!gl_on)
      return GL_OFF;
    else if (to_on && lost)
      return GL_FALLBACK;
    else
      return GL_LOCKED;
  endfunction

endpackage

// File: rtl/gvs_sync_edge.sv
module gvs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  for (genvar i = 0; i <= LAST; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign rise_pulse = chain[LAST-1] & ~chain[LAST];

endmodule

// File: rtl/gvs_skew_timer.sv
module gvs_skew_timer #(
  parameter int SKEW_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cancel,
  input  logic [SKEW_W-1:0] skew,
  output logic              busy,
  output logic              expire
);
  logic [SKEW_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (start && (skew != '0)) begin
      busy  <= 1'b1;
      cnt_q <= skew - 1'b1;
    end
  end

  assign expire = busy && (cnt_q == '0);

endmodule

// File: rtl/gvs_frame_arbiter.sv
module gvs_frame_arbiter
  import gvs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gl_mode_e mode,
  input  logic     vs_edge,
  input  logic     frame_end,
  input  logic     skew_zero,
  input  logic     tmr_busy,
  input  logic     tmr_expire,
  output logic     tmr_start,
  output logic     tmr_cancel,
  output logic     restart_q,
  output logic     wait_q
);
  logic restart_d;
  logic wait_d;

  always_comb begin
    tmr_start  = 1'b0;
    tmr_cancel = 1'b0;
    restart_d  = 1'b0;
    wait_d     = 1'b0;
    unique case (mode)
      GL_OFF: begin
        tmr_cancel = 1'b1;
        restart_d  = frame_end;
      end
      GL_FALLBACK: begin
        tmr_cancel = 1'b1;
        restart_d  = frame_end | wait_q | tmr_busy;
      end
      default: begin
        tmr_start = vs_edge & ~tmr_busy;
        restart_d = tmr_expire | (tmr_start & skew_zero);
        wait_d    = (wait_q | frame_end) & ~restart_d;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      restart_q <= 1'b0;
      wait_q    <= 1'b0;
    end else begin
      restart_q <= restart_d;
      wait_q    <= wait_d;
    end
  end

endmodule

// File: rtl/gvs_ctrl.sv
module gvs_ctrl
  import gvs_pkg::*;
#(
  parameter int SKEW_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_vsync,
  input  logic                vin_sync_lost,
  input  logic                tmr_frame_end,
  input  logic [SKEW_W+1:0]   ctrl_word,
  output logic                frame_restart,
  output logic                wait_status
);
  localparam int GL_BIT = SKEW_W;
  localparam int TO_BIT = SKEW_W + 1;

  logic [SKEW_W-1:0] skew_cfg;
  logic              gl_on;
  logic              to_on;
  gl_mode_e          mode;
  logic              vs_edge;
  logic              tmr_start;
  logic              tmr_cancel;
  logic              tmr_busy;
  logic              tmr_expire;

  assign skew_cfg = ctrl_word[SKEW_W-1:0];
  assign gl_on    = ctrl_word[GL_BIT];
  assign to_on    = ctrl_word[TO_BIT];
  assign mode     = pick_mode(gl_on, to_on, vin_sync_lost);

  gvs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_in   (ext_vsync),
    .rise_pulse (vs_edge)
  );

  gvs_skew_timer #(.SKEW_W(SKEW_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .cancel (tmr_cancel),
    .skew   (skew_cfg),
    .busy   (tmr_busy),
    .expire (tmr_expire)
  );

  gvs_frame_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .vs_edge    (vs_edge),
    .frame_end  (tmr_frame_end),
    .skew_zero  (skew_cfg == '0),
    .tmr_busy   (tmr_busy),
    .tmr_expire (tmr_expire),
    .tmr_start  (tmr_start),
    .tmr_cancel (tmr_cancel),
    .restart_q  (frame_restart),
    .wait_q     (wait_status)
  );

endmodule

// File: rtl/gvs_ctrl_chk.sv
module gvs_ctrl_chk #(
  parameter int SKEW_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              vin_sync_lost,
  input logic              tmr_frame_end,
  input logic [SKEW_W+1:0] ctrl_word,
  input logic              vs_edge,
  input logic              tmr_busy,
  input logic              frame_restart,
  input logic              wait_status
);
  logic gl_on, to_on, fb_on, locked;
  assign gl_on  = ctrl_word[SKEW_W];
  assign to_on  = ctrl_word[SKEW_W+1];
  assign fb_on  = gl_on && to_on && vin_sync_lost;
  assign locked = gl_on && !fb_on;

  // R5: genlock off, restart mirrors end-of-frame one clock later
  a_r5_off_follows: assert property (@(posedge clk) disable iff (rst)
    !gl_on |=> (frame_restart == $past(tmr_frame_end)));

  // R5: genlock off keeps the wait status low
  a_r5_off_no_wait: assert property (@(posedge clk) disable iff (rst)
    !gl_on |=> !wait_status);

  // R2: zero skew, accepted edge gives restart on the next cycle
  a_r2_zero_skew: assert property (@(posedge clk) disable iff (rst)
    (locked && vs_edge && !tmr_busy && ctrl_word[SKEW_W-1:0] == '0) |=> frame_restart);

  // R6: end of frame while locked gives either hold or restart
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (locked && tmr_frame_end) |=> (wait_status || frame_restart));

  // R6: wait and restart never coincide
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wait_status && frame_restart));

  // R8: fallback turns end of frame into an immediate restart
  a_r8_fallback: assert property (@(posedge clk) disable iff (rst)
    (fb_on && tmr_frame_end) |=> (frame_restart && !wait_status));

  // R9: fallback releases a held wait at once
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (fb_on && wait_status) |=> (frame_restart && !wait_status));

  // R10: fallback during a countdown restarts at once and ends it
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (fb_on && tmr_busy) |=> (frame_restart && !tmr_busy));

endmodule

bind gvs_ctrl gvs_ctrl_chk #(.SKEW_W(SKEW_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .vin_sync_lost (vin_sync_lost),
  .tmr_frame_end (tmr_frame_end),
  .ctrl_word     (ctrl_word),
  .vs_edge       (vs_edge),
  .tmr_busy      (tmr_busy),
  .frame_restart (frame_restart),
  .wait_status   (wait_status)
);

// File: tb/tb_gvs_ctrl.sv
`timescale 1ns/1ps
module tb_gvs_ctrl;
  localparam int SKEW_W = 18;
  localparam int CW     = SKEW_W + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ext_vsync = 1'b0;
  logic          vin_sync_lost = 1'b0;
  logic          tmr_frame_end = 1'b0;
  logic [CW-1:0] ctrl_word = '0;
  logic          frame_restart;
  logic          wait_status;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gvs_ctrl #(.SKEW_W(SKEW_W)) dut (
    .clk           (clk),
    .rst           (rst),
    .ext_vsync     (ext_vsync),
    .vin_sync_lost (vin_sync_lost),
    .tmr_frame_end (tmr_frame_end),
    .ctrl_word     (ctrl_word),
    .frame_restart (frame_restart),
    .wait_status   (wait_status)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input bit gl, input bit to, input int skew);
    logic [CW-1:0] w;
    w = '0;
    w[SKEW_W-1:0] = skew[SKEW_W-1:0];
    w[18] = gl;   // R11 genlock enable bit
    w[19] = to;   // R11 timeout enable bit
    return w;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    ext_vsync = 1'b0; vin_sync_lost = 1'b0; tmr_frame_end = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic pulse_fe();
    tmr_frame_end = 1'b1; tick(); tmr_frame_end = 1'b0;
  endtask

  // raise VSYNC, return edge index of first restart and pulse count
  task automatic rise_and_watch(input int win, output int first, output int cnt);
    first = -1; cnt = 0;
    ext_vsync = 1'b1;
    for (int k = 1; k <= win; k++) begin
      tick();
      if (frame_restart) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
    ext_vsync = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 restart after reset", frame_restart, 0);
    check("R1 wait after reset", wait_status, 0);
    ctrl_word = mk(1, 0, 0);
    pulse_fe();
    check("R1 wait set before reset", wait_status, 1);
    do_reset();
    check("R1 wait cleared by reset", wait_status, 0);
  endtask

  task automatic t_skew(input int n, input string req);
    int first, cnt;
    do_reset();
    ctrl_word = mk(1, 0, n);
    rise_and_watch(n + 12, first, cnt);
    check({req, " restart edge index"}, first, 3 + n);
    check({req, " single pulse"}, cnt, 1);
  endtask

  task automatic t_second_edge();
    int cnt = 0;
    do_reset();
    ctrl_word = mk(1, 0, 6);
    ext_vsync = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      tick();
      if (k == 2) ext_vsync = 1'b0;
      if (k == 3) ext_vsync = 1'b1;
      if (frame_restart) begin
        cnt++;
        check("R4 pulse at edge 9", k, 9);
      end
    end
    check("R4 second edge dropped", cnt, 1);
    ext_vsync = 1'b0;
  endtask

  task automatic t_off();
    int first, cnt;
    do_reset();
    ctrl_word = mk(0, 1, 3);
    pulse_fe();
    check("R5 restart follows frame end", frame_restart, 1);
    check("R5 wait stays low", wait_status, 0);
    tick();
    check("R5 restart single cycle", frame_restart, 0);
    rise_and_watch(12, first, cnt);
    check("R5 vsync ignored when off", cnt, 0);
  endtask

  task automatic t_hold(input bit to, input string req);
    int first, cnt;
    do_reset();
    ctrl_word = mk(1, to, 0);
    vin_sync_lost = !to;   // R7 case: loss reported but timeout disabled
    pulse_fe();
    check({req, " wait set after frame end"}, wait_status, 1);
    check({req, " no restart while holding"}, frame_restart, 0);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (frame_restart || !wait_status) cnt++;
    end
    check({req, " still holding"}, cnt, 0);
    ext_vsync = 1'b1;
    tick(); tick(); tick();
    check({req, " restart from vsync"}, frame_restart, 1);
    check({req, " wait cleared with restart"}, wait_status, 0);
    ext_vsync = 1'b0; vin_sync_lost = 1'b0;
    repeat (4) tick();
  endtask

  task automatic t_fallback();
    int first, cnt;
    do_reset();
    ctrl_word = mk(1, 1, 2);
    vin_sync_lost = 1'b1;
    pulse_fe();
    check("R8 immediate restart", frame_restart, 1);
    check("R8 no wait", wait_status, 0);
    tick();
    rise_and_watch(12, first, cnt);
    check("R8 vsync ignored in fallback", cnt, 0);
    vin_sync_lost = 1'b0;
  endtask

  task automatic t_release_wait();
    do_reset();
    ctrl_word = mk(1, 1, 4);
    pulse_fe();
    tick();
    check("R9 holding before loss", wait_status, 1);
    vin_sync_lost = 1'b1;
    tick();
    check("R9 restart on loss", frame_restart, 1);
    check("R9 wait cleared", wait_status, 0);
    tick();
    check("R9 restart single cycle", frame_restart, 0);
    vin_sync_lost = 1'b0;
  endtask

  task automatic t_abort_skew();
    int cnt = 0;
    do_reset();
    ctrl_word = mk(1, 1, 10);
    ext_vsync = 1'b1;
    repeat (5) tick();
    check("R10 no early restart", frame_restart, 0);
    vin_sync_lost = 1'b1;
    tick();
    check("R10 restart on loss during skew", frame_restart, 1);
    for (int k = 0; k < 20; k++) begin
      tick();
      if (frame_restart) cnt++;
    end
    check("R10 no late pulse", cnt, 0);
    ext_vsync = 1'b0; vin_sync_lost = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_skew(0, "R2");
    t_skew(1, "R3");
    t_skew(5, "R3 R11");
    t_second_edge();
    t_off();
    t_hold(1'b1, "R6");
    t_hold(1'b0, "R7");
    t_fallback();
    t_release_wait();
    t_abort_skew();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule